// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor's byte-wide load/store port and a memory port that moves one whole line per transfer. Each line slot keeps a tag, a valid flag and a dirty flag next to its data. A request is split into byte offset, slot index and tag. A hit is served from the slot. A miss first writes back a dirty occupant, if there is one, and then refills the slot with the line that holds the requested byte.

Stores are kept in the cache. A store hit changes only the slot and marks it dirty. A store miss fetches the line first and then merges the byte into it. Loads and stores both allocate a slot on a miss. Main memory sees only line-aligned, full-line transfers. The processor issues a request while `cpu_busy` is low and gets the result on a one-cycle `cpu_done` pulse.

Top module: `dm_wb_cache`

## Requirements
- R1: After reset `cpu_busy`, `cpu_done` and `mem_req` are low, and every slot is invalid, so the first access to any address misses.
- R2: Address bits [2:0] select the byte and bits [5:3] select the slot. All remaining upper bits form the tag, so addresses with equal index but different tags conflict.
- R3: A load hit raises `cpu_done` on the second rising edge after acceptance, returns the addressed byte and issues no memory request.
- R4: A load miss on a clean or invalid slot issues one line read at the line base (offset zero) and returns the addressed byte of the fetched line.
- R5: A store hit updates only the addressed byte in the slot, sets the slot dirty and issues no memory request. `cpu_rdata` returns the stored byte.
- R6: A store miss first reads the whole line from memory and then merges the byte into it. The slot is dirty afterwards.
- R7: On a miss whose slot is valid and dirty, the whole old line is written (`mem_we`=1) to the address {stored tag, index, zero offset} before the refill read.
- R8: A slot filled by a load miss is clean, so evicting it later produces no write-back.
- R9: `mem_req` is high only while `cpu_busy` is high. Address, direction and write data stay stable until the cycle `mem_ack` is sampled high.
- R10: A request is taken only while `cpu_busy` is low. A request presented while busy is ignored. `cpu_done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, taken while not busy |
| cpu_we | input | 1 | 1 = store byte, 0 = load byte |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_busy | output | 1 | Access in progress |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Loaded byte (stored byte for stores), valid with cpu_done |
| mem_req | output | 1 | Line transfer request |
| mem_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | ADDR_W | Line-aligned memory address |
| mem_wdata | output | 8*LINE_BYTES | Line being written back |
| mem_ack | input | 1 | One-cycle acknowledge of the current transfer |
| mem_rdata | input | 8*LINE_BYTES | Fetched line, valid with mem_ack on reads |

## Verification
The checks assume that memory raises `mem_ack` for exactly one cycle and only while `mem_req` is high, with `mem_rdata` valid in that cycle. They also assume that the processor holds at most one access outstanding. The bench's memory responder waits two cycles after seeing a request and then acknowledges once. The processor driver presents a request only while busy is low, except for one deliberate stray pulse used to show that a request made while busy is ignored.

// File: rtl/dm_cache_pkg.sv
package dm_cache_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COMPARE,
        ST_WRITEBACK,
        ST_REFILL,
        ST_RESPOND
    } cache_state_e;
endpackage

// File: rtl/dm_cache_tags.sv
module dm_cache_tags #(
    parameter int NUM_LINES = 8,
    parameter int TAG_W     = 10,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             wr_en,
    input  logic             wr_dirty,
    input  logic [TAG_W-1:0] wr_tag,
    output logic             valid,
    output logic             dirty,
    output logic [TAG_W-1:0] tag
);
    logic [NUM_LINES-1:0] valid_q, valid_d;
    logic [NUM_LINES-1:0] dirty_q, dirty_d;
    logic [TAG_W-1:0]     tag_q [NUM_LINES];

    always_comb begin
        valid_d = valid_q;
        dirty_d = dirty_q;
        if (wr_en) begin
            valid_d[idx] = 1'b1;
            dirty_d[idx] = wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            valid_q <= valid_d;
            dirty_q <= dirty_d;
        end
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_tag
        always_ff @(posedge clk) begin
            if (wr_en && idx == IDX_W'(g)) tag_q[g] <= wr_tag;
        end
    end

    assign valid = valid_q[idx];
    assign dirty = dirty_q[idx];
    assign tag   = tag_q[idx];
endmodule

// File: rtl/dm_cache_data.sv
module dm_cache_data #(
    parameter int NUM_LINES = 8,
    parameter int LINE_W    = 64,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_line,
    output logic [LINE_W-1:0] rd_line
);
    logic [LINE_W-1:0] line_q [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (wr_en && idx == IDX_W'(g)) line_q[g] <= wr_line;
        end
    end

    assign rd_line = line_q[idx];
endmodule

// File: rtl/dm_cache_ctrl.sv
module dm_cache_ctrl
    import dm_cache_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 8,
    parameter int NUM_LINES  = 8,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
    localparam int LINE_W    = 8 * LINE_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic              cpu_busy,
    output logic              cpu_done,
    output logic [7:0]        cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [LINE_W-1:0] mem_rdata,
    output logic [IDX_W-1:0]  slot_idx,
    input  logic              slot_valid,
    input  logic              slot_dirty,
    input  logic [TAG_W-1:0]  slot_tag,
    output logic              tag_wr_en,
    output logic              tag_wr_dirty,
    output logic [TAG_W-1:0]  tag_wr_tag,
    input  logic [LINE_W-1:0] slot_line,
    output logic              line_wr_en,
    output logic [LINE_W-1:0] line_wr_data
);
    typedef struct packed {
        cache_state_e      state;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        wdata;
        logic [7:0]        rdata;
    } ctrl_t;

    ctrl_t r_q, r_d;

    logic [OFF_W-1:0] req_off;
    logic [TAG_W-1:0] req_tag;
    logic             hit;

    assign req_off  = r_q.addr[OFF_W-1:0];
    assign req_tag  = r_q.addr[ADDR_W-1 -: TAG_W];
    assign slot_idx = r_q.addr[OFF_W +: IDX_W];
    assign hit      = slot_valid && (slot_tag == req_tag);

    function automatic logic [7:0] pick_byte(input logic [LINE_W-1:0] line,
                                             input logic [OFF_W-1:0]  off);
        return line[{off, 3'b000} +: 8];
    endfunction

    function automatic logic [LINE_W-1:0] put_byte(input logic [LINE_W-1:0] line,
                                                   input logic [OFF_W-1:0]  off,
                                                   input logic [7:0]        b);
        logic [LINE_W-1:0] res;
        res = line;
        res[{off, 3'b000} +: 8] = b;
        return res;
    endfunction

    always_comb begin
        r_d          = r_q;
        tag_wr_en    = 1'b0;
        tag_wr_dirty = 1'b0;
        tag_wr_tag   = req_tag;
        line_wr_en   = 1'b0;
        line_wr_data = slot_line;
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        mem_addr     = '0;
        mem_wdata    = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (cpu_req) begin
                    r_d.state = ST_COMPARE;
                    r_d.we    = cpu_we;
                    r_d.addr  = cpu_addr;
                    r_d.wdata = cpu_wdata;
                end
            end
            ST_COMPARE: begin
                if (hit) begin
                    if (r_q.we) begin
                        line_wr_en   = 1'b1;
                        line_wr_data = put_byte(slot_line, req_off, r_q.wdata);
                        tag_wr_en    = 1'b1;
                        tag_wr_dirty = 1'b1;
                        r_d.rdata    = r_q.wdata;
                    end else begin
                        r_d.rdata    = pick_byte(slot_line, req_off);
                    end
                    r_d.state = ST_RESPOND;
                end else if (slot_valid && slot_dirty) begin
                    r_d.state = ST_WRITEBACK;
                end else begin
                    r_d.state = ST_REFILL;
                end
            end
            ST_WRITEBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {slot_tag, slot_idx, {OFF_W{1'b0}}};
                mem_wdata = slot_line;
                if (mem_ack) r_d.state = ST_REFILL;
            end
            ST_REFILL: begin
                mem_req  = 1'b1;
                mem_addr = {req_tag, slot_idx, {OFF_W{1'b0}}};
                if (mem_ack) begin
                    line_wr_en   = 1'b1;
                    tag_wr_en    = 1'b1;
                    tag_wr_dirty = r_q.we;
                    if (r_q.we) begin
                        line_wr_data = put_byte(mem_rdata, req_off, r_q.wdata);
                        r_d.rdata    = r_q.wdata;
                    end else begin
                        line_wr_data = mem_rdata;
                        r_d.rdata    = pick_byte(mem_rdata, req_off);
                    end
                    r_d.state = ST_RESPOND;
                end
            end
            ST_RESPOND: r_d.state = ST_IDLE;
            default:    r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.we    <= 1'b0;
            r_q.addr  <= '0;
            r_q.wdata <= '0;
            r_q.rdata <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cpu_busy  = (r_q.state != ST_IDLE);
    assign cpu_done  = (r_q.state == ST_RESPOND);
    assign cpu_rdata = r_q.rdata;
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 8,
    parameter int NUM_LINES  = 8,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
    localparam int LINE_W    = 8 * LINE_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic              cpu_busy,
    output logic              cpu_done,
    output logic [7:0]        cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [LINE_W-1:0] mem_rdata
);
    logic [IDX_W-1:0]  slot_idx;
    logic              slot_valid, slot_dirty;
    logic [TAG_W-1:0]  slot_tag;
    logic              tag_wr_en, tag_wr_dirty;
    logic [TAG_W-1:0]  tag_wr_tag;
    logic [LINE_W-1:0] slot_line;
    logic              line_wr_en;
    logic [LINE_W-1:0] line_wr_data;

    dm_cache_ctrl #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .NUM_LINES(NUM_LINES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .slot_idx(slot_idx), .slot_valid(slot_valid), .slot_dirty(slot_dirty),
        .slot_tag(slot_tag), .tag_wr_en(tag_wr_en), .tag_wr_dirty(tag_wr_dirty),
        .tag_wr_tag(tag_wr_tag), .slot_line(slot_line),
        .line_wr_en(line_wr_en), .line_wr_data(line_wr_data)
    );

    dm_cache_tags #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .idx(slot_idx),
        .wr_en(tag_wr_en), .wr_dirty(tag_wr_dirty), .wr_tag(tag_wr_tag),
        .valid(slot_valid), .dirty(slot_dirty), .tag(slot_tag)
    );

    dm_cache_data #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_data (
        .clk(clk), .idx(slot_idx), .wr_en(line_wr_en),
        .wr_line(line_wr_data), .rd_line(slot_line)
    );
endmodule

// File: rtl/dm_wb_cache_chk.sv
module dm_wb_cache_chk #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_busy,
    input logic              cpu_done,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr
);
    // R9
    mem_under_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> cpu_busy);

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R4
    line_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R3
    done_quiet_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !mem_req);

    // R10
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_done) |-> $past(cpu_busy));
endmodule

bind dm_wb_cache dm_wb_cache_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_busy(cpu_busy), .cpu_done(cpu_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr)
);

// File: tb/dm_wb_cache_tb.sv
`timescale 1ns/1ps
module dm_wb_cache_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_busy, cpu_done;
    logic [7:0]  cpu_rdata;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [63:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;

    int checks = 0, failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dm_wb_cache u_dut (.*);

    // memory contents seen by the responder and by the reference model
    logic [63:0] rmem [int];
    logic [63:0] mmem [int];
    bit          ev_we   [$];
    logic [15:0] ev_addr [$];
    logic [63:0] ev_data [$];

    function automatic logic [63:0] init_line(input logic [15:0] base);
        logic [63:0] l;
        for (int b = 0; b < 8; b++) l[b*8 +: 8] = base[10:3] ^ 8'(8'h3c + b*17);
        return l;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // memory responder: two-cycle wait, single-cycle ack
    int wait_cnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            wait_cnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (!cpu_busy) chk(0, "R9", "mem_req without busy", 1, 0);
            if (wait_cnt < 2) wait_cnt++;
            else begin
                wait_cnt = 0;
                mem_ack = 1'b1;
                ev_we.push_back(mem_we);
                ev_addr.push_back(mem_addr);
                ev_data.push_back(mem_wdata);
                if (mem_we) rmem[int'(mem_addr)] = mem_wdata;
                else mem_rdata = rmem.exists(int'(mem_addr)) ? rmem[int'(mem_addr)]
                                                             : init_line(mem_addr);
            end
        end
    end

    // reference model state
    bit          m_valid [8];
    bit          m_dirty [8];
    logic [9:0]  m_tag   [8];
    logic [63:0] m_line  [8];

    function automatic logic [63:0] model_mem(input logic [15:0] base);
        return mmem.exists(int'(base)) ? mmem[int'(base)] : init_line(base);
    endfunction

    task automatic access(input bit we, input logic [15:0] a, input logic [7:0] d,
                          input string req, input bit stray = 0);
        int idx = int'(a[5:3]);
        logic [9:0] tg = a[15:6];
        int off = int'(a[2:0]);
        bit hit = m_valid[idx] && m_tag[idx] == tg;
        bit wb  = !hit && m_valid[idx] && m_dirty[idx];
        logic [15:0] wb_addr = {m_tag[idx], a[5:3], 3'b000};
        logic [63:0] wb_data = m_line[idx];
        logic [15:0] base = {a[15:3], 3'b000};
        logic [7:0]  exp_r;
        int cnt = 0;
        int exp_ev;
        if (wb) mmem[int'(wb_addr)] = wb_data;
        if (!hit) begin
            m_line[idx] = model_mem(base);
            m_dirty[idx] = 0;
            m_valid[idx] = 1;
            m_tag[idx] = tg;
        end
        if (we) begin
            m_line[idx][off*8 +: 8] = d;
            m_dirty[idx] = 1;
            exp_r = d;
        end else exp_r = m_line[idx][off*8 +: 8];

        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 0;
        if (stray) begin
            cpu_req = 1; cpu_we = 1; cpu_addr = 16'h0330; cpu_wdata = 8'hee;
            @(negedge clk);
            cnt++;
            cpu_req = 0;
        end
        while (!cpu_done && cnt < 100) begin
            @(negedge clk);
            cnt++;
        end
        chk(cpu_done, req, "done seen", cpu_done, 1);
        chk(cpu_rdata == exp_r, req, $sformatf("rdata @%h", a), cpu_rdata, exp_r);
        if (hit) chk(cnt == 1, "R3", "hit latency", cnt, 1);
        exp_ev = hit ? 0 : (wb ? 2 : 1);
        chk(ev_we.size() == exp_ev, wb ? "R7" : (hit ? req : "R8"), "transfer count",
            ev_we.size(), exp_ev);
        if (!hit && ev_we.size() == exp_ev) begin
            if (wb) begin
                chk(ev_we[0] == 1 && ev_addr[0] == wb_addr, "R7", "writeback addr",
                    ev_addr[0], wb_addr);
                chk(ev_data[0] == wb_data, "R7", "writeback data", ev_data[0], wb_data);
            end
            chk(ev_we[exp_ev-1] == 0 && ev_addr[exp_ev-1] == base, we ? "R6" : "R4",
                "refill addr", ev_addr[exp_ev-1], base);
        end
        ev_we.delete(); ev_addr.delete(); ev_data.delete();
        @(negedge clk);
        chk(!cpu_busy && !cpu_done, "R10", "idle after done", {cpu_busy, cpu_done}, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_valid[i] = 0; m_dirty[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!cpu_busy && !cpu_done && !mem_req, "R1", "reset outputs",
            {cpu_busy, cpu_done, mem_req}, 0);
        access(0, 16'h0010, 0, "R1");          // empty cache: miss
        access(0, 16'h0013, 0, "R3");          // hit
        access(0, 16'h0017, 0, "R3");
        access(1, 16'h0128, 8'h5a, "R6");      // store miss allocates
        access(0, 16'h0128, 0, "R6");          // merged byte visible
        access(1, 16'h012b, 8'hc3, "R5");      // store hit
        access(0, 16'h002a, 0, "R7");          // dirty victim to 0x0128
        access(0, 16'h0000, 0, "R2");          // conflict chain
        access(0, 16'h0040, 0, "R2");
        access(0, 16'h0080, 0, "R8");
        access(1, 16'h0083, 8'h77, "R5");
        access(0, 16'h0000, 0, "R7");
        access(1, 16'hfff8, 8'h99, "R2");      // all-ones tag
        access(0, 16'h0038, 0, "R7");
        access(0, 16'h0100, 0, "R10", 1);      // stray store while busy
        access(0, 16'h0330, 0, "R10");         // stray store never landed
        for (int i = 0; i < 8; i++) access(1, 16'(16'h0400 + i*8 + i), 8'(i + 1), "R2");
        for (int i = 0; i < 8; i++) access(0, 16'(16'h0400 + i*8 + i), 0, "R2");
        for (int i = 0; i < 8; i++) access(0, 16'(16'h0800 + i*8), 0, "R7");
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule